// File: doc/BRIEF.md
# CPU Video Memory Plane Mapper

This block sits between a byte-wide CPU port and a video memory built from four 8-bit planes that share one address bus. For every CPU access it drives a single plane address to all four planes together, a per-plane write enable, and the write byte. On a read, all four planes return a byte and the block forwards the byte of one selected plane to the CPU.

The low CPU address bit does not address memory directly. In the interleaved (odd/even) modes it picks the even or the odd planes. In the chained modes it is folded into plane selection, and the freed plane address bits are refilled from a page bit or from high CPU address bits. Requests are registered once before they reach the planes. Read data returns two clock edges after the request is sampled.

Top module: `vmem_plane_mapper`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `pl_we`, `pl_re` and `cpu_rvalid` are all 0.
- R2: A request sampled at a clock edge appears on `pl_addr` after that edge. With `chain2` and `chain4` both low, `pl_addr` equals `cpu_addr[15:0]`.
- R3: A write sampled with no odd/even and no chain mode sets `pl_we` to `map_mask` (bit n is plane n) and `pl_wdata` to `cpu_wdata`. A sampled non-write leaves `pl_we` at 0.
- R4: With `seq_oddeven` high and `chain4` low, a write with `cpu_addr[0]`=0 also clears planes 1 and 3, and a write with `cpu_addr[0]`=1 also clears planes 0 and 2. The result is ANDed with `map_mask`.
- R5: With `chain2` high and `chain4` low, `pl_addr[15:1]` equals `cpu_addr[15:1]` and `pl_addr[0]` is the page bit. `page_src` selects the page bit: 0 or 3 take `page_reg`, 1 takes `cpu_addr[16]`, 2 takes `cpu_addr[14]`.
- R6: With `chain4` high, a write enables only plane `cpu_addr[1:0]`, masked by `map_mask`. `pl_addr` is `{cpu_addr[15:2], cpu_addr[15], cpu_addr[14]}`.
- R7: `chain4` overrides `chain2`, `seq_oddeven` and `gfx_oddeven` when several are set at once.
- R8: A read sets `pl_re` for one cycle after the sampling edge. Two edges after the sampling edge, `cpu_rvalid` is 1 and `cpu_rdata` holds the byte of plane `{read_map[1], b}`. Here b is `cpu_addr[0]` when `gfx_oddeven` is high and `read_map[0]` when it is low.
- R9: With `chain4` high, a read returns the byte of plane `cpu_addr[1:0]`, whatever `read_map` holds.
- R10: A read never raises `pl_we`. A read followed in the next cycle by a write to the same location returns the value stored before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request this cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 17 | CPU byte address |
| cpu_wdata | input | 8 | Write byte |
| map_mask | input | 4 | Per-plane write permission |
| seq_oddeven | input | 1 | Write-side even/odd plane masking by A0 |
| gfx_oddeven | input | 1 | Read-side even/odd plane choice by A0 |
| chain2 | input | 1 | Replace plane address bit 0 with a page bit |
| chain4 | input | 1 | A[1:0] selects the plane; A14/A15 refill the low address bits |
| read_map | input | 2 | Plane chosen for reads |
| page_reg | input | 1 | Page bit held in a control register |
| page_src | input | 2 | Page bit source for chain2 |
| pl_addr | output | 16 | Address shared by all planes |
| pl_we | output | 4 | Per-plane write enable |
| pl_re | output | 1 | Read strobe to all planes |
| pl_wdata | output | 8 | Byte written to enabled planes |
| pl_rdata | input | 32 | Bytes from planes 0..3 (plane n in bits 8n+7:8n) |
| cpu_rdata | output | 8 | Byte returned to the CPU |
| cpu_rvalid | output | 1 | `cpu_rdata` is valid |

## Verification
A read's return stage and the next request's issue stage share a cycle. When a read is followed at once by a write, the block drives the write enables in the same cycle that it captures the read plane selection for the returning byte. The bench provokes this with a read and a write to the same plane location back to back, in that order. It passes when the CPU receives the byte from before the write and a later read sees the new byte. A reference model predicts the plane address, enables and returned byte for every combination of the mode bits, the two low address bits, the mask and the read map, and compares them with the outputs on every clock.

// File: rtl/vpm_pkg.sv
package vpm_pkg;
    localparam int NPLANES = 4;
    localparam int PSEL_W  = $clog2(NPLANES);

    typedef enum logic [1:0] {
        MAP_LINEAR = 2'd0,
        MAP_CHAIN2 = 2'd1,
        MAP_CHAIN4 = 2'd2
    } map_kind_e;

    typedef enum logic [1:0] {
        PG_FROM_REG  = 2'd0,
        PG_FROM_A16  = 2'd1,
        PG_FROM_A14  = 2'd2,
        PG_FROM_REG2 = 2'd3
    } page_src_e;
endpackage

// File: rtl/vpm_addr_gen.sv
module vpm_addr_gen
    import vpm_pkg::*;
#(
    parameter int PLANE_AW = 16,
    parameter int CPU_AW   = 17
) (
    input  map_kind_e            kind,
    input  logic [CPU_AW-1:0]    cpu_addr,
    input  logic [1:0]           page_src,
    input  logic                 page_reg,
    output logic [PLANE_AW-1:0]  plane_addr
);
    localparam int TOP_BIT = PLANE_AW - 1;
    localparam int MID_BIT = PLANE_AW - 2;
    localparam int EXT_BIT = PLANE_AW;

    logic page_bit;

    always_comb begin
        unique case (page_src_e'(page_src))
            PG_FROM_A16: page_bit = cpu_addr[EXT_BIT];
            PG_FROM_A14: page_bit = cpu_addr[MID_BIT];
            default:     page_bit = page_reg;
        endcase
    end

    always_comb begin
        unique case (kind)
            MAP_CHAIN4: plane_addr = {cpu_addr[TOP_BIT:2], cpu_addr[TOP_BIT], cpu_addr[MID_BIT]};
            MAP_CHAIN2: plane_addr = {cpu_addr[TOP_BIT:1], page_bit};
            default:    plane_addr = cpu_addr[TOP_BIT:0];
        endcase
    end
endmodule

// File: rtl/vpm_plane_enables.sv
module vpm_plane_enables
    import vpm_pkg::*;
(
    input  map_kind_e             kind,
    input  logic [PSEL_W-1:0]     addr_lo,
    input  logic [NPLANES-1:0]    map_mask,
    input  logic                  seq_oddeven,
    input  logic                  write,
    output logic [NPLANES-1:0]    we
);
    for (genvar g = 0; g < NPLANES; g++) begin : g_plane
        logic hit;
        always_comb begin
            if (kind == MAP_CHAIN4)
                hit = (addr_lo == PSEL_W'(g));
            else if (seq_oddeven)
                hit = (addr_lo[0] == 1'(g % 2));
            else
                hit = 1'b1;
        end
        assign we[g] = write & map_mask[g] & hit;
    end
endmodule

// File: rtl/vpm_read_select.sv
module vpm_read_select
    import vpm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [NPLANES*DATA_W-1:0] lanes,
    input  logic [PSEL_W-1:0]         sel,
    output logic [DATA_W-1:0]         byte_o
);
    logic [DATA_W-1:0] lane [NPLANES];

    for (genvar g = 0; g < NPLANES; g++) begin : g_lane
        assign lane[g] = lanes[g*DATA_W +: DATA_W];
    end

    assign byte_o = lane[sel];
endmodule

// File: rtl/vmem_plane_mapper.sv
module vmem_plane_mapper
    import vpm_pkg::*;
#(
    parameter int PLANE_AW = 16,
    parameter int CPU_AW   = 17,
    parameter int DATA_W   = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cpu_req,
    input  logic                        cpu_we,
    input  logic [CPU_AW-1:0]           cpu_addr,
    input  logic [DATA_W-1:0]           cpu_wdata,
    input  logic [NPLANES-1:0]          map_mask,
    input  logic                        seq_oddeven,
    input  logic                        gfx_oddeven,
    input  logic                        chain2,
    input  logic                        chain4,
    input  logic [PSEL_W-1:0]           read_map,
    input  logic                        page_reg,
    input  logic [1:0]                  page_src,
    output logic [PLANE_AW-1:0]         pl_addr,
    output logic [NPLANES-1:0]          pl_we,
    output logic                        pl_re,
    output logic [DATA_W-1:0]           pl_wdata,
    input  logic [NPLANES*DATA_W-1:0]   pl_rdata,
    output logic [DATA_W-1:0]           cpu_rdata,
    output logic                        cpu_rvalid
);
    typedef struct packed {
        logic [PLANE_AW-1:0] addr;
        logic [NPLANES-1:0]  we;
        logic                re;
        logic [DATA_W-1:0]   wdata;
        logic [PSEL_W-1:0]   rsel_issue;
        logic                rvalid;
        logic [PSEL_W-1:0]   rsel_ret;
    } state_t;

    state_t st_d, st_q;

    map_kind_e           kind;
    logic [PLANE_AW-1:0] addr_c;
    logic [NPLANES-1:0]  we_c;
    logic [PSEL_W-1:0]   rsel_c;
    logic                rd_c;
    logic                wr_c;

    assign kind = chain4 ? MAP_CHAIN4 : (chain2 ? MAP_CHAIN2 : MAP_LINEAR);
    assign wr_c = cpu_req & cpu_we;
    assign rd_c = cpu_req & ~cpu_we;

    vpm_addr_gen #(.PLANE_AW(PLANE_AW), .CPU_AW(CPU_AW)) u_addr (
        .kind       (kind),
        .cpu_addr   (cpu_addr),
        .page_src   (page_src),
        .page_reg   (page_reg),
        .plane_addr (addr_c)
    );

    vpm_plane_enables u_en (
        .kind        (kind),
        .addr_lo     (cpu_addr[PSEL_W-1:0]),
        .map_mask    (map_mask),
        .seq_oddeven (seq_oddeven),
        .write       (wr_c),
        .we          (we_c)
    );

    always_comb begin
        if (kind == MAP_CHAIN4)
            rsel_c = cpu_addr[PSEL_W-1:0];
        else
            rsel_c = {read_map[PSEL_W-1], gfx_oddeven ? cpu_addr[0] : read_map[0]};
    end

    always_comb begin
        st_d            = st_q;
        st_d.we         = we_c;
        st_d.re         = rd_c;
        st_d.rvalid     = st_q.re;
        if (cpu_req)
            st_d.addr   = addr_c;
        if (wr_c)
            st_d.wdata  = cpu_wdata;
        if (rd_c)
            st_d.rsel_issue = rsel_c;
        if (st_q.re)
            st_d.rsel_ret   = st_q.rsel_issue;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    vpm_read_select #(.DATA_W(DATA_W)) u_rd (
        .lanes  (pl_rdata),
        .sel    (st_q.rsel_ret),
        .byte_o (cpu_rdata)
    );

    assign pl_addr    = st_q.addr;
    assign pl_we      = st_q.we;
    assign pl_re      = st_q.re;
    assign pl_wdata   = st_q.wdata;
    assign cpu_rvalid = st_q.rvalid;
endmodule

// File: rtl/vpm_checks.sv
module vpm_checks #(
    parameter int PLANE_AW = 16,
    parameter int CPU_AW   = 17
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cpu_req,
    input logic                cpu_we,
    input logic [CPU_AW-1:0]   cpu_addr,
    input logic [3:0]          map_mask,
    input logic                seq_oddeven,
    input logic                chain2,
    input logic                chain4,
    input logic [1:0]          page_src,
    input logic                page_reg,
    input logic [PLANE_AW-1:0] pl_addr,
    input logic [3:0]          pl_we,
    input logic                pl_re,
    input logic                cpu_rvalid
);
    assert_we_within_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pl_we & ~$past(map_mask)) == 4'b0);

    assert_no_we_without_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_req && cpu_we) |=> pl_we == 4'b0);

    assert_read_excludes_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pl_re |-> pl_we == 4'b0);

    assert_even_masks_odd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && seq_oddeven && !chain4 && !cpu_addr[0])
        |=> (pl_we[1] == 1'b0 && pl_we[3] == 1'b0));

    assert_odd_masks_even_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && seq_oddeven && !chain4 && cpu_addr[0])
        |=> (pl_we[0] == 1'b0 && pl_we[2] == 1'b0));

    assert_chain4_single_plane_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && chain4) |=> $onehot0(pl_we));

    assert_chain2_page_reg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && chain2 && !chain4 && page_src == 2'd0)
        |=> pl_addr[0] == $past(page_reg));

    assert_linear_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !chain2 && !chain4)
        |=> pl_addr == $past(cpu_addr[PLANE_AW-1:0]));

    assert_rvalid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cpu_rvalid == $past(pl_re));
endmodule

bind vmem_plane_mapper vpm_checks #(.PLANE_AW(PLANE_AW), .CPU_AW(CPU_AW)) u_vpm_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_req     (cpu_req),
    .cpu_we      (cpu_we),
    .cpu_addr    (cpu_addr),
    .map_mask    (map_mask),
    .seq_oddeven (seq_oddeven),
    .chain2      (chain2),
    .chain4      (chain4),
    .page_src    (page_src),
    .page_reg    (page_reg),
    .pl_addr     (pl_addr),
    .pl_we       (pl_we),
    .pl_re       (pl_re),
    .cpu_rvalid  (cpu_rvalid)
);

// File: tb/vmem_plane_mapper_test.sv
module vmem_plane_mapper_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_req, cpu_we;
    logic [16:0] cpu_addr;
    logic [7:0]  cpu_wdata;
    logic [3:0]  map_mask;
    logic        seq_oddeven, gfx_oddeven, chain2, chain4;
    logic [1:0]  read_map;
    logic        page_reg;
    logic [1:0]  page_src;
    logic [15:0] pl_addr;
    logic [3:0]  pl_we;
    logic        pl_re;
    logic [7:0]  pl_wdata;
    logic [31:0] pl_rdata;
    logic [7:0]  cpu_rdata;
    logic        cpu_rvalid;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vmem_plane_mapper uut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .map_mask(map_mask),
        .seq_oddeven(seq_oddeven), .gfx_oddeven(gfx_oddeven),
        .chain2(chain2), .chain4(chain4), .read_map(read_map),
        .page_reg(page_reg), .page_src(page_src), .pl_addr(pl_addr),
        .pl_we(pl_we), .pl_re(pl_re), .pl_wdata(pl_wdata),
        .pl_rdata(pl_rdata), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid)
    );

    // four-plane storage model, synchronous read
    logic [7:0] pmem [int];
    always @(posedge clk) begin
        for (int p = 0; p < 4; p++) begin
            if (pl_we[p]) pmem[p*65536 + int'(pl_addr)] = pl_wdata;
        end
        if (pl_re) begin
            for (int p = 0; p < 4; p++) begin
                int k;
                k = p*65536 + int'(pl_addr);
                pl_rdata[p*8 +: 8] <= pmem.exists(k) ? pmem[k] : 8'h00;
            end
        end
    end

    // reference state
    logic [7:0] ref_mem [int];
    int         exp_q[$];
    string      tag_q[$];
    bit         rd_p0 = 0, rd_p1 = 0;

    task automatic chk(string tag, bit ok, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        rd_p1 <= rd_p0;
        rd_p0 <= rst_n && cpu_req && !cpu_we;
    end

    // per-clock comparison of the return path
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R8 rvalid", cpu_rvalid == rd_p1, int'(cpu_rvalid), int'(rd_p1));
            if (cpu_rvalid) begin
                if (exp_q.size() == 0) begin
                    chk("R8 unexpected data", 1'b0, int'(cpu_rdata), -1);
                end else begin
                    int    e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(t, int'(cpu_rdata) == e, int'(cpu_rdata), e);
                end
            end
        end
    end

    function automatic int ref_addr(int a);
        int pg;
        if (chain4) return (a & 16'hFFFC) | ((a >> 14) & 1) | (((a >> 15) & 1) << 1);
        if (chain2) begin
            case (page_src)
                2'd1:    pg = (a >> 16) & 1;
                2'd2:    pg = (a >> 14) & 1;
                default: pg = int'(page_reg);
            endcase
            return (a & 16'hFFFE) | pg;
        end
        return a & 16'hFFFF;
    endfunction

    function automatic int ref_we(int a);
        int m;
        m = int'(map_mask);
        if (chain4) return m & (1 << (a & 3));
        if (seq_oddeven) m = m & (((a & 1) != 0) ? 4'b1010 : 4'b0101);
        return m;
    endfunction

    function automatic int ref_rplane(int a);
        if (chain4) return a & 3;
        return (int'(read_map[1]) << 1) | (gfx_oddeven ? (a & 1) : int'(read_map[0]));
    endfunction

    function automatic string mode_tag(bit is_addr);
        if (chain4) return (chain2 || seq_oddeven || gfx_oddeven) ? "R7" : "R6";
        if (chain2) return is_addr ? "R5" : (seq_oddeven ? "R4" : "R3");
        if (seq_oddeven && !is_addr) return "R4";
        return is_addr ? "R2" : "R3";
    endfunction

    // one access; called at a negedge, returns at the following negedge
    task automatic access(bit w, int a, int d);
        int ea, ew, k;
        cpu_req   = 1'b1;
        cpu_we    = w;
        cpu_addr  = 17'(a);
        cpu_wdata = 8'(d);
        ea = ref_addr(a);
        ew = w ? ref_we(a) : 0;
        if (w) begin
            for (int p = 0; p < 4; p++)
                if (ew[p]) ref_mem[p*65536 + ea] = 8'(d);
        end else begin
            k = ref_rplane(a)*65536 + ea;
            exp_q.push_back(ref_mem.exists(k) ? int'(ref_mem[k]) : 0);
            tag_q.push_back(chain4 ? "R9 data" : "R8 data");
        end
        @(posedge clk);
        @(negedge clk);
        chk(mode_tag(1'b1), int'(pl_addr) == ea, int'(pl_addr), ea);
        chk(w ? mode_tag(1'b0) : "R10 we", int'(pl_we) == ew, int'(pl_we), ew);
        chk("R8 re", pl_re == !w, int'(pl_re), int'(!w));
        if (w) chk("R3 wdata", int'(pl_wdata) == (d & 8'hFF), int'(pl_wdata), d & 8'hFF);
    endtask

    task automatic idle(int n);
        cpu_req = 1'b0;
        cpu_we  = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(int bits);
        seq_oddeven = bits[0];
        gfx_oddeven = bits[1];
        chain2      = bits[2];
        chain4      = bits[3];
    endtask

    initial begin
        rst_n = 1'b0;
        cpu_req = 0; cpu_we = 0; cpu_addr = '0; cpu_wdata = '0;
        map_mask = 4'hF; read_map = 0; page_reg = 0; page_src = 0;
        set_mode(0);
        // R1: outputs quiet under reset
        repeat (3) begin
            @(negedge clk);
            chk("R1 reset", pl_we == 0 && !pl_re && !cpu_rvalid,
                int'({pl_we, pl_re, cpu_rvalid}), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", pl_we == 0 && !pl_re && !cpu_rvalid,
            int'({pl_we, pl_re, cpu_rvalid}), 0);

        // fill all four planes at a set of locations in linear mode
        set_mode(0);
        map_mask = 4'hF;
        for (int i = 0; i < 64; i++) access(1'b1, i*1031 + (i << 10), i*7 + 3);
        idle(1);

        // sweep mode bits, low address bits and the mask (R2..R7)
        for (int md = 0; md < 16; md++) begin
            set_mode(md);
            for (int mk = 0; mk < 16; mk++) begin
                map_mask = 4'(mk);
                for (int lo = 0; lo < 4; lo++) begin
                    int a;
                    a = ((md*4099 + mk*613 + lo*97) << 2 & 17'h1FFFC) | lo;
                    page_reg = 1'(mk >> 1);
                    page_src = 2'(lo);
                    access(1'b1, a, md*16 + mk + lo);
                end
            end
        end
        idle(2);

        // reads under every mode, read map and low address bits (R8, R9)
        for (int md = 0; md < 16; md++) begin
            set_mode(md);
            for (int rm = 0; rm < 4; rm++) begin
                read_map = 2'(rm);
                for (int lo = 0; lo < 4; lo++) begin
                    int a;
                    a = ((md*4099 + rm*613 + lo*97) << 2 & 17'h1FFFC) | lo;
                    page_src = 2'(rm);
                    page_reg = 1'(lo >> 1);
                    access(1'b0, a, 0);
                end
            end
        end
        idle(3);

        // page sources with A16 and A14 toggled (R5)
        set_mode(4'b0100);
        map_mask = 4'hF;
        for (int ps = 0; ps < 4; ps++) begin
            page_src = 2'(ps);
            for (int hb = 0; hb < 8; hb++) begin
                page_reg = hb[2];
                access(1'b1, (hb[0] << 16) | (hb[1] << 14) | 17'h0234, ps*8 + hb);
                access(1'b0, (hb[0] << 16) | (hb[1] << 14) | 17'h0234, 0);
            end
        end
        idle(3);

        // R10: read then write the same location back to back
        set_mode(0);
        map_mask = 4'hF;
        read_map = 2'd2;
        access(1'b1, 17'h0555, 8'hA5);
        idle(1);
        access(1'b0, 17'h0555, 0);
        access(1'b1, 17'h0555, 8'h3C);
        access(1'b0, 17'h0555, 0);
        idle(4);

        chk("R8 drained", exp_q.size() == 0, exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule